// File: doc/BRIEF.md
# Output Saturator with Near-Full-Scale Flag

This block is the last stage of a stereo audio decimation path. Each output sample period it accepts one wide signed sample per channel, with a strobe. It limits each sample to an 18-bit two's complement range and presents the results one clock later. Values that do not fit are held at the positive or negative end of the range. The limits are not symmetric: the top of the range is 131071 and the bottom is -131072. No sign change is applied anywhere, so a positive input always gives a non-negative output.

Alongside the data, the block drives an overload flag. The flag rises when either channel's limited sample has a magnitude of 116818 or more, which is about 1 dB below full scale. Once raised, the flag stays up through at least one more full sample period after the last sample that met the threshold. A standby input releases the flag pin to high impedance. During standby the internal flag state keeps running, and the pin shows it again as soon as standby is removed.

Top module: `sat_clip_ovl`

## Requirements
- R1: A sample whose value lies within [-131072, 131071] appears unchanged, with its sign, on the matching 18-bit output.
- R2: A sample above 131071 gives exactly 131071 on its output.
- R3: A sample below -131072 gives exactly -131072 on its output.
- R4: out_valid is high for exactly one cycle, in the cycle after each in_valid. While no strobe arrives, both outputs hold their last values.
- R5: After a strobed sample where either channel's limited magnitude is at least 116818, the flag reads 1 in the following cycle. A sample with magnitudes of at most 116817 on both channels does not set the flag.
- R6: With the default hold of 2, the flag stays at 1 after one further non-qualifying sample. It drops to 0 after the second non-qualifying sample. Cycles without a strobe do not change the flag.
- R7: While standby is 1, ovl_pin is released to high impedance and never drives 1. When standby returns to 0, ovl_pin shows the held flag again.
- R8: After reset, out_valid, both outputs and the flag are 0.
- R9: An output of -131072 counts as magnitude 131072 and sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | 1 releases ovl_pin to high impedance |
| in_valid | input | 1 | Strobe for one new sample pair |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| out_valid | output | 1 | Output pair updated in this cycle |
| out_left | output | 18 | Limited left sample, signed |
| out_right | output | 18 | Limited right sample, signed |
| ovl_pin | output | 1 | Near-full-scale flag, high impedance in standby |

## Verification
The bench uses the default parameters: 24-bit inputs, 18-bit outputs, a threshold of 116818 and a hold of two samples. These defaults keep both saturation limits and the threshold edges close together in value. Random draws are weighted toward a few ranges: the values just around ±116818, the values around ±131072, arbitrary 24-bit words, and small values. Over a few hundred samples, both limits, both sides of the threshold and the flag's hold and release sequences are each exercised many times. Directed cases add exact -131072, a pin check during standby, and idle gaps between strobes.

// File: rtl/sat_clip_ovl.sv
module sat_clip_ovl #(
  parameter int IN_W   = 24,
  parameter int OUT_W  = 18,
  parameter int THRESH = 116818,
  parameter int HOLD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    standby,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_left,
  input  logic signed [IN_W-1:0]  in_right,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_left,
  output logic signed [OUT_W-1:0] out_right,
  output logic                    ovl_pin
);
  localparam int EXT = IN_W - OUT_W + 1;
  localparam int CW  = $clog2(HOLD + 1);
  localparam logic [OUT_W-1:0] TOP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] BOT = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W:0]   TH  = (OUT_W+1)'(THRESH);

  function automatic logic [OUT_W-1:0] limit(input logic [IN_W-1:0] x);
    logic [EXT-1:0] hi;
    hi = x[IN_W-1:OUT_W-1];
    if (&hi || ~|hi) return x[OUT_W-1:0];
    return x[IN_W-1] ? BOT : TOP;
  endfunction

  function automatic logic [OUT_W:0] mag(input logic [OUT_W-1:0] s);
    logic [OUT_W:0] e;
    e = {s[OUT_W-1], s};
    return s[OUT_W-1] ? -e : e;
  endfunction

  logic [OUT_W-1:0] lim_l, lim_r;
  logic             hit;
  logic [CW-1:0]    cnt;
  logic             flag_q;

  assign lim_l  = limit(in_left);
  assign lim_r  = limit(in_right);
  assign hit    = (mag(lim_l) >= TH) || (mag(lim_r) >= TH);
  assign flag_q = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      cnt       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= lim_l;
        out_right <= lim_r;
        if (hit)             cnt <= CW'(HOLD);
        else if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  assign ovl_pin = standby ? 1'bz : flag_q;
endmodule

module sat_clip_ovl_chk #(
  parameter int IN_W   = 24,
  parameter int OUT_W  = 18,
  parameter int THRESH = 116818
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_left,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_left,
  input logic signed [OUT_W-1:0] out_right,
  input logic                    flag_q
);
  localparam logic signed [IN_W-1:0]  MAX_IN  = IN_W'(2**(OUT_W-1) - 1);
  localparam logic signed [IN_W-1:0]  MIN_IN  = -IN_W'(2**(OUT_W-1));
  localparam logic signed [OUT_W-1:0] MAX_OUT = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] MIN_OUT = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0] TH_OUT  = OUT_W'(THRESH);

  // R4
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));
  // R2
  pos_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left > MAX_IN) |=> out_left == MAX_OUT);
  // R3
  neg_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left < MIN_IN) |=> out_left == MIN_OUT);
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_left >= TH_OUT || out_right >= TH_OUT)) |-> flag_q);
  // R9
  min_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_left == MIN_OUT) |-> flag_q);
endmodule

bind sat_clip_ovl sat_clip_ovl_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right), .flag_q(flag_q)
);

// File: tb/tb_sat_clip_ovl.sv
module tb_sat_clip_ovl;
  localparam int HOLD = 2;
  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, in_valid = 1'b0;
  logic signed [23:0] in_left = '0, in_right = '0;
  logic out_valid, ovl_pin;
  logic signed [17:0] out_left, out_right;
  int checks = 0, fails = 0, exp_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sat_clip_ovl dut (.clk(clk), .rst_n(rst_n), .standby(standby), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .ovl_pin(ovl_pin));

  function automatic longint ref_clip(longint x);
    if (x > 131071) return 131071;
    if (x < -131072) return -131072;
    return x;
  endfunction

  function automatic bit ref_hit(longint l, longint r);
    longint a = ref_clip(l), b = ref_clip(r);
    if (a < 0) a = -a;
    if (b < 0) b = -b;
    return (a >= 116818) || (b >= 116818);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(longint l, longint r);
    in_left = 24'(l); in_right = 24'(r); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (ref_hit(l, r)) exp_cnt = HOLD;
    else if (exp_cnt > 0) exp_cnt--;
    chk("R4 valid", out_valid, 1);
    chk("R1/R2/R3 left", out_left, ref_clip(l));
    chk("R1/R2/R3 right", out_right, ref_clip(r));
    if (!standby) chk("R5/R6 flag", ovl_pin, exp_cnt != 0);
  endtask

  task automatic idle();
    logic signed [17:0] pl = out_left, pr = out_right;
    @(negedge clk);
    chk("R4 idle valid", out_valid, 0);
    chk("R4 hold left", out_left, pl);
    chk("R4 hold right", out_right, pr);
    if (!standby) chk("R6 idle flag", ovl_pin, exp_cnt != 0);
  endtask

  function automatic longint pick();
    longint s = ($urandom % 2) ? 1 : -1;
    case ($urandom % 5)
      0: return s * (116815 + longint'($urandom % 7));
      1: return s * (131068 + longint'($urandom % 8));
      2: return longint'($signed(24'($urandom)));
      3: return longint'($urandom % 2000) - 1000;
      default: return -131072;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd41));
    repeat (3) @(negedge clk);
    chk("R8 valid", out_valid, 0);
    chk("R8 left", out_left, 0);
    chk("R8 right", out_right, 0);
    chk("R8 flag", ovl_pin, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(1000, -2000);             // R1
    send(200000, 5);               // R2
    idle();
    send(-3, -8388608);            // R3
    send(100, 100);                // R6 first non-qualifying
    chk("R6 still set", ovl_pin, 1);
    send(100, 100);
    chk("R6 cleared", ovl_pin, 0);
    send(116817, -116817);         // R5 just below
    chk("R5 below", ovl_pin, 0);
    send(0, -116818);              // R5 at threshold
    chk("R5 at", ovl_pin, 1);
    send(0, 0); send(0, 0);
    send(-131072, 0);              // R9
    chk("R9 min flags", ovl_pin, 1);
    send(0, 0); send(0, 0);
    standby = 1'b1;                // R7
    send(131071, 0);
    @(negedge clk);
    checks++;
    if (ovl_pin === 1'b1) begin
      fails++;
      $display("FAIL R7 standby actual=%b expected=z", ovl_pin);
    end
    standby = 1'b0;
    #1;
    chk("R7 release", ovl_pin, 1);
    for (int i = 0; i < 400; i++) begin
      send(pick(), pick());
      if ($urandom % 4 == 0) idle();
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule